// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is a slave serial port that sits in the system clock domain. A host drives three lines, enable, shift clock and data, and watches one open-drain return line. Every transaction opens with an eight-bit address. The address either picks one of two 24-bit configuration registers to write or asks for a status frame to be read back. Data shifted in for a write is held in a shadow register. It reaches the configuration outputs only when enable drops at the end of the transaction. A neighbouring block decodes those outputs.

The three host lines are oversampled through synchronizer flops, and clock edges are found in the system clock domain. While enable is low, the return line is a status pin. A three-bit selector in configuration register 2 chooses what it shows. While a read is running, the line carries the captured status frame one bit per shift clock. The open-drain output is modelled as `do_low_o`: 1 pulls the line low and 0 leaves it open, which reads as high.

Top module: `scp_port`

## Requirements
- R1: Address bits are sent first-bit-first. The sequences 0,0,0,1,0,1,0,0 and 1,0,0,1,0,1,0,0 select a write to register 1 and register 2. The sequence 0,1,0,1,0,1,0,0 selects a read. With the first bit at bit 0, these are 0x28, 0x29 and 0x2A. Any other address makes the rest of the transaction change no register and leaves the return line open.
- R2: A write carries 24 data bits after the address. The first data bit lands in bit 0 of the register, and bits after the 24th are ignored.
- R3: Written data reaches the configuration outputs only when enable falls. A write that ends with fewer than 24 data bits changes nothing.
- R4: The read frame presents, in order, the I/O pin 2 level, the I/O pin 1 level, the lock flag, and count bits 19 down to 0. Each later clock gives a 0. Every bit is shown as a line level, 1 = open and 0 = pulled low, and is presented after a falling edge of the shift clock.
- R5: Frame values are captured at the moment the port recognises the read address. Changes to the inputs after that point do not appear in the frame.
- R6: While enable is high, the return line is open during address and write phases and follows the frame during a read, whatever the selector holds.
- R7: While enable is low, the selector in register 2 bits [2:0] drives the line. Code 1 pulls it low when not locked. Code 2 pulls it low when a measurement is complete. Codes 0, 3, 4 and 7 leave it open.
- R8: Selector code 5 mirrors the I/O pin 1 level and code 6 mirrors the I/O pin 2 level, where a low pin gives a low line. The line stays open if register 2 bit 3 (pin 1) or bit 4 (pin 2) marks that pin as an output.
- R9: The frame lock flag is 0 if loss of lock was seen at any time since the end of the previous transaction. Each enable fall reloads the flag from the live lock input.
- R10: Transactions work with the shift clock idling either high or low.
- R11: After reset, register 1 reads 0x800000 (crystal-select bit 23 set), register 2 reads 0, the line is open and the lock flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_in | input | 1 | Transaction enable from the host, asynchronous |
| sclk_in | input | 1 | Shift clock from the host, asynchronous |
| sdi_in | input | 1 | Serial data from the host, asynchronous |
| io1_in | input | 1 | Level of I/O pin 1 |
| io2_in | input | 1 | Level of I/O pin 2 |
| locked_in | input | 1 | Lock detector, 1 = locked |
| meas_done_in | input | 1 | Measurement-complete flag |
| count_in | input | 20 | Measurement count value |
| cfg1_o | output | 24 | Committed configuration register 1 |
| cfg2_o | output | 24 | Committed configuration register 2 |
| do_low_o | output | 1 | Open-drain return line, 1 = pull low |

## Verification
Two collisions matter. The first is a read starting while the lock input is dropping: the sticky lock flag, its reload at the enable fall and the frame capture can all act in the same cycle. The bench drops lock between transactions, starts a read, and changes the count and pin inputs just after the address. The frame must show the old values and a cleared flag, and a following read must show the reloaded flag. The second is a selector that asks to show loss of lock while a write is in progress: the line must stay open until enable falls, and only then follow the selector.

// File: rtl/scp_pkg.sv
// Package: shared transaction modes and address codes of the serial control port.
// Assumes address bits are collected first-bit-at-LSB.
package scp_pkg;
    typedef enum logic [2:0] {
        M_IDLE = 3'd0,
        M_ADDR = 3'd1,
        M_WR1  = 3'd2,
        M_WR2  = 3'd3,
        M_RD   = 3'd4,
        M_SKIP = 3'd5
    } mode_e;

    localparam logic [7:0] ADDR_WR1 = 8'h28;
    localparam logic [7:0] ADDR_WR2 = 8'h29;
    localparam logic [7:0] ADDR_RD  = 8'h2A;
endpackage

// File: rtl/scp_sync.sv
// Module: synchronizes a vector of asynchronous pins and flags their edges.
// Assumes each pin stays stable for several system clocks (oversampled).
module scp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // first capture flop of each pin
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= pin_i;
                end
            end else begin : g_next
                // further metastability stages
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[gi] <= '0;
                    else        pipe[gi] <= pipe[gi-1];
                end
            end
        end
    endgenerate

    // previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pipe[STAGES-1];
    end

    assign lvl_o  = pipe[STAGES-1];
    assign rise_o = pipe[STAGES-1] & ~prev_q;
    assign fall_o = ~pipe[STAGES-1] & prev_q;
endmodule

// File: rtl/scp_rx.sv
// Module: address decode, write shifter and commit of the two config registers.
// Assumes synchronized enable/clock/data; data sampled on shift-clock rise.
module scp_rx
    import scp_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 24,
    parameter logic [23:0] RST1   = 24'h800000,
    parameter logic [23:0] RST2   = 24'h000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl,
    input  logic              ce_rise,
    input  logic              ce_fall,
    input  logic              cl_rise,
    input  logic              di_lvl,
    output mode_e             mode_o,
    output logic              rd_enter_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cfg2_o
);
    localparam int AC_W = $clog2(ADDR_W + 1);
    localparam int DC_W = $clog2(DATA_W + 1);
    localparam logic [AC_W-1:0] ACNT_LAST = AC_W'(ADDR_W - 1);
    localparam logic [DC_W-1:0] DCNT_FULL = DC_W'(DATA_W);

    mode_e             mode_q;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] data_sh;
    logic [AC_W-1:0]   acnt_q;
    logic [DC_W-1:0]   dcnt_q;
    logic              addr_done;
    mode_e             dec_mode;

    // next address value with the new bit entering at the MSB
    assign addr_nxt  = {di_lvl, addr_sh[ADDR_W-1:1]};
    assign addr_done = ce_lvl && cl_rise && (mode_q == M_ADDR) && (acnt_q == ACNT_LAST);

    // decode the completed address into a transaction mode
    always_comb begin
        case (addr_nxt)
            ADDR_WR1: dec_mode = M_WR1;
            ADDR_WR2: dec_mode = M_WR2;
            ADDR_RD:  dec_mode = M_RD;
            default:  dec_mode = M_SKIP;
        endcase
    end

    assign rd_enter_o = addr_done && (dec_mode == M_RD);

    // transaction sequencing: address collection then data shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_IDLE;
            addr_sh <= '0;
            data_sh <= '0;
            acnt_q  <= '0;
            dcnt_q  <= '0;
        end else if (ce_rise) begin
            mode_q <= M_ADDR;
            acnt_q <= '0;
            dcnt_q <= '0;
        end else if (ce_fall) begin
            mode_q <= M_IDLE;
        end else if (ce_lvl && cl_rise) begin
            case (mode_q)
                M_ADDR: begin
                    addr_sh <= addr_nxt;
                    acnt_q  <= acnt_q + 1'b1;
                    if (acnt_q == ACNT_LAST) mode_q <= dec_mode;
                end
                M_WR1, M_WR2: begin
                    if (dcnt_q != DCNT_FULL) begin
                        data_sh <= {di_lvl, data_sh[DATA_W-1:1]};
                        dcnt_q  <= dcnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // commit of complete writes on the enable falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_o <= RST1[DATA_W-1:0];
            cfg2_o <= RST2[DATA_W-1:0];
        end else if (ce_fall && dcnt_q == DCNT_FULL) begin
            if (mode_q == M_WR1) cfg1_o <= data_sh;
            if (mode_q == M_WR2) cfg2_o <= data_sh;
        end
    end

    assign mode_o = mode_q;

    AST_COMMIT_AT_CE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg1_o) || !$stable(cfg2_o)) |-> $past(ce_fall)); // R3
    AST_DATA_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt_q <= DCNT_FULL); // R2
    AST_ADDR_ONLY_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_IDLE) |-> $stable(addr_sh)); // R1
endmodule

// File: rtl/scp_tx.sv
// Module: sticky lock flag, read-frame capture and serial shift-out.
// Assumes the frame is loaded on address recognition and advanced on clock falls.
module scp_tx #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_fall,
    input  logic             cl_fall,
    input  logic             rd_enter,
    input  logic             rd_active,
    input  logic             locked,
    input  logic             io1,
    input  logic             io2,
    input  logic [CNT_W-1:0] count,
    output logic             rd_bit_o,
    output logic             rd_valid_o
);
    localparam int FRAME_W = CNT_W + 3;

    logic               lock_sticky;
    logic [FRAME_W-1:0] frame_q;
    logic               primed_q;

    // lock flag: cleared by any loss of lock, reloaded at each transaction end
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_sticky <= 1'b1;
        else if (ce_fall) lock_sticky <= locked;
        else if (!locked) lock_sticky <= 1'b0;
    end

    // frame capture at read entry, shift on each later clock fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            primed_q <= 1'b0;
        end else if (rd_enter) begin
            frame_q  <= {io2, io1, lock_sticky, count};
            primed_q <= 1'b0;
        end else if (rd_active && cl_fall) begin
            if (primed_q) frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            else          primed_q <= 1'b1;
        end
    end

    assign rd_bit_o   = frame_q[FRAME_W-1];
    assign rd_valid_o = primed_q;

    AST_FRAME_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_q) |-> $past(rd_enter || (rd_active && cl_fall))); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !ce_fall) |=> !lock_sticky); // R9
endmodule

// File: rtl/scp_dout.sv
// Module: drives the open-drain return line (1 = pull low).
// Assumes the selector and pin-direction bits come from committed register 2.
module scp_dout
    import scp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_lvl,
    input  mode_e      mode,
    input  logic       rd_bit,
    input  logic       rd_valid,
    input  logic [2:0] sel,
    input  logic       io1_is_out,
    input  logic       io2_is_out,
    input  logic       locked,
    input  logic       meas_done,
    input  logic       io1,
    input  logic       io2,
    output logic       do_low_o
);
    logic idle_low;

    // status choice while no transaction is running
    always_comb begin
        case (sel)
            3'd1:    idle_low = !locked;
            3'd2:    idle_low = meas_done;
            3'd5:    idle_low = !io1_is_out && !io1;
            3'd6:    idle_low = !io2_is_out && !io2;
            default: idle_low = 1'b0;
        endcase
    end

    // registered line driver: frame in reads, open in other transactions
    always_ff @(posedge clk) begin
        if (!rst_n)      do_low_o <= 1'b0;
        else if (ce_lvl) do_low_o <= (mode == M_RD) && rd_valid && !rd_bit;
        else             do_low_o <= idle_low;
    end

    AST_OUTPUT_PIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_lvl && sel == 3'd5 && io1_is_out) |=> !do_low_o); // R8
endmodule

// File: rtl/scp_port.sv
// Module: top of the addressed three-wire serial control port.
// Assumes host pins are asynchronous and slow relative to clk.
module scp_port
    import scp_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 24,
    parameter int          CNT_W       = 20,
    parameter int          SEL_LSB     = 0,
    parameter int          IO1_DIR_BIT = 3,
    parameter int          IO2_DIR_BIT = 4,
    parameter logic [23:0] RST1        = 24'h800000,
    parameter logic [23:0] RST2        = 24'h000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_in,
    input  logic              sclk_in,
    input  logic              sdi_in,
    input  logic              io1_in,
    input  logic              io2_in,
    input  logic              locked_in,
    input  logic              meas_done_in,
    input  logic [CNT_W-1:0]  count_in,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cfg2_o,
    output logic              do_low_o
);
    localparam int PIN_CE = 0;
    localparam int PIN_CL = 1;
    localparam int PIN_DI = 2;

    logic [2:0] lvl, rise, fall;
    mode_e      mode;
    logic       rd_enter, rd_bit, rd_valid;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sdi_in, sclk_in, ce_in}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    scp_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST1(RST1), .RST2(RST2)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl     (lvl[PIN_CE]),
        .ce_rise    (rise[PIN_CE]),
        .ce_fall    (fall[PIN_CE]),
        .cl_rise    (rise[PIN_CL]),
        .di_lvl     (lvl[PIN_DI]),
        .mode_o     (mode),
        .rd_enter_o (rd_enter),
        .cfg1_o     (cfg1_o),
        .cfg2_o     (cfg2_o)
    );

    scp_tx #(.CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_fall    (fall[PIN_CE]),
        .cl_fall    (fall[PIN_CL]),
        .rd_enter   (rd_enter),
        .rd_active  (lvl[PIN_CE] && mode == M_RD),
        .locked     (locked_in),
        .io1        (io1_in),
        .io2        (io2_in),
        .count      (count_in),
        .rd_bit_o   (rd_bit),
        .rd_valid_o (rd_valid)
    );

    scp_dout u_dout (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl     (lvl[PIN_CE]),
        .mode       (mode),
        .rd_bit     (rd_bit),
        .rd_valid   (rd_valid),
        .sel        (cfg2_o[SEL_LSB +: 3]),
        .io1_is_out (cfg2_o[IO1_DIR_BIT]),
        .io2_is_out (cfg2_o[IO2_DIR_BIT]),
        .locked     (locked_in),
        .meas_done  (meas_done_in),
        .io1        (io1_in),
        .io2        (io2_in),
        .do_low_o   (do_low_o)
    );

    AST_OPEN_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[PIN_CE] && (mode == M_WR1 || mode == M_WR2 || mode == M_SKIP)) |=> !do_low_o); // R6
    AST_SKIP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SKIP) |=> ($stable(cfg1_o) && $stable(cfg2_o))); // R1
endmodule

// File: tb/scp_port_bench.sv
module scp_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic        io1 = 1'b1, io2 = 1'b1, locked = 1'b1, mdone = 1'b0;
    logic [19:0] cnt = '0;
    logic [23:0] cfg1, cfg2;
    logic        do_low;
    logic        idle_hi = 1'b0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;
    localparam int HALF = 6;

    always #10 clk = ~clk;

    scp_port u_scp_port (
        .clk(clk), .rst_n(rst_n), .ce_in(ce), .sclk_in(sclk), .sdi_in(sdi),
        .io1_in(io1), .io2_in(io2), .locked_in(locked), .meas_done_in(mdone),
        .count_in(cnt), .cfg1_o(cfg1), .cfg2_o(cfg2), .do_low_o(do_low)
    );

    localparam int NV = 7;
    localparam logic [7:0]  V_ADDR [NV] = '{8'h28, 8'h29, 8'h2B, 8'h28, 8'h14, 8'h29, 8'h28};
    localparam logic [23:0] V_DATA [NV] = '{24'h123456, 24'h000A50, 24'hFFFFFF, 24'hFFFFFF,
                                            24'h000000, 24'h000000, 24'h5A5A5A};
    localparam logic [23:0] V_EXP1 [NV] = '{24'h123456, 24'h123456, 24'h123456, 24'hFFFFFF,
                                            24'hFFFFFF, 24'hFFFFFF, 24'h5A5A5A};
    localparam logic [23:0] V_EXP2 [NV] = '{24'h000000, 24'h000A50, 24'h000A50, 24'h000A50,
                                            24'h000A50, 24'h000000, 24'h000000};

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic begin_txn();
        sclk = idle_hi;
        wait_clk(HALF);
        ce = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = v[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic end_txn();
        sclk = idle_hi;
        wait_clk(HALF);
        ce = 1'b0;
        wait_clk(12);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [23:0] d);
        begin_txn();
        send_bits({24'd0, a}, 8);
        send_bits({8'd0, d}, 24);
        end_txn();
    endtask

    // read 24 frame bits as line levels; first bit in bit 23
    task automatic read_frame(output logic [23:0] lv, input bit mid_change);
        begin_txn();
        send_bits(32'h2A, 8);
        if (mid_change) begin
            cnt = 20'h00000;
            io2 = 1'b0;
            io1 = 1'b1;
        end
        for (int k = 0; k < 24; k++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            lv[23-k] = ~do_low;
            sclk = 1'b1;
            wait_clk(HALF);
        end
        end_txn();
    endtask

    initial begin
        wait_clk(200000 - 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] lv, expf;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R11 reset defaults
        chk(cfg1 == 24'h800000, "R11 cfg1", cfg1, 24'h800000);
        chk(cfg2 == 24'h0, "R11 cfg2", cfg2, 0);
        chk(do_low == 1'b0, "R11 line", do_low, 0);

        // table: R1 address decode, R2 bit order
        for (int i = 0; i < NV; i++) begin
            write_reg(V_ADDR[i], V_DATA[i]);
            chk(cfg1 == V_EXP1[i], "R1 R2 cfg1 vector", cfg1, V_EXP1[i]);
            chk(cfg2 == V_EXP2[i], "R1 R2 cfg2 vector", cfg2, V_EXP2[i]);
            chk(do_low == 1'b0, "R7 sel0 open", do_low, 0);
        end

        // R3: no commit before enable falls; extra bits ignored (R2)
        begin_txn();
        send_bits(32'h28, 8);
        send_bits(32'hABCDEF, 24);
        send_bits(32'h1, 3);
        wait_clk(10);
        chk(cfg1 == 24'h5A5A5A, "R3 held while enable high", cfg1, 24'h5A5A5A);
        end_txn();
        chk(cfg1 == 24'hABCDEF, "R3 R2 commit at fall", cfg1, 24'hABCDEF);
        // R3: short write discarded
        begin_txn();
        send_bits(32'h29, 8);
        send_bits(32'hFFF, 12);
        end_txn();
        chk(cfg2 == 24'h0, "R3 short write", cfg2, 0);

        // R7 selector codes while idle
        write_reg(8'h29, 24'h000001);
        locked = 1'b0;
        wait_clk(4);
        chk(do_low == 1'b1, "R7 unlock low", do_low, 1);
        // R6: open during write despite selector
        begin_txn();
        send_bits(32'h28, 8);
        send_bits(32'h000777, 10);
        chk(do_low == 1'b0, "R6 open during write", do_low, 0);
        send_bits(32'h0001, 14);
        end_txn();
        chk(do_low == 1'b1, "R6 R7 back to status", do_low, 1);
        locked = 1'b1;
        wait_clk(4);
        chk(do_low == 1'b0, "R7 locked open", do_low, 0);
        write_reg(8'h29, 24'h000002);
        mdone = 1'b1;
        wait_clk(4);
        chk(do_low == 1'b1, "R7 meas done low", do_low, 1);
        mdone = 1'b0;
        wait_clk(4);
        chk(do_low == 1'b0, "R7 meas pending open", do_low, 0);
        write_reg(8'h29, 24'h000003);
        mdone = 1'b1;
        locked = 1'b0;
        wait_clk(4);
        chk(do_low == 1'b0, "R7 code3 open", do_low, 0);
        mdone = 1'b0;
        locked = 1'b1;

        // R8 pin mirror and output-direction masking
        write_reg(8'h29, 24'h000005);
        io1 = 1'b0;
        wait_clk(4);
        chk(do_low == 1'b1, "R8 io1 low", do_low, 1);
        io1 = 1'b1;
        wait_clk(4);
        chk(do_low == 1'b0, "R8 io1 high", do_low, 0);
        io1 = 1'b0;
        write_reg(8'h29, 24'h00000D);
        chk(do_low == 1'b0, "R8 io1 output open", do_low, 0);
        write_reg(8'h29, 24'h000006);
        io2 = 1'b0;
        wait_clk(4);
        chk(do_low == 1'b1, "R8 io2 low", do_low, 1);
        write_reg(8'h29, 24'h000016);
        chk(do_low == 1'b0, "R8 io2 output open", do_low, 0);

        // R4 R5 R9 read frame with sticky flag; selector 1 active (R6)
        write_reg(8'h29, 24'h000001);
        io2 = 1'b1; io1 = 1'b0; cnt = 20'h53980;
        locked = 1'b0;
        wait_clk(3);
        locked = 1'b1;
        wait_clk(3);
        read_frame(lv, 1'b1);
        expf = {1'b1, 1'b0, 1'b0, 20'h53980, 1'b0};
        chk(lv == expf, "R4 R5 R9 frame sticky", lv, expf);
        read_frame(lv, 1'b0);
        expf = {1'b0, 1'b1, 1'b1, 20'h00000, 1'b0};
        chk(lv == expf, "R9 R4 frame reloaded", lv, expf);

        // R10 idle-high shift clock
        idle_hi = 1'b1;
        sclk = 1'b1;
        wait_clk(6);
        write_reg(8'h28, 24'h3C0F81);
        chk(cfg1 == 24'h3C0F81, "R10 idle-high write", cfg1, 24'h3C0F81);
        io2 = 1'b0; io1 = 1'b1; cnt = 20'hE10;
        read_frame(lv, 1'b0);
        expf = {1'b0, 1'b1, 1'b1, 20'h00E10, 1'b0};
        chk(lv == expf, "R10 idle-high read", lv, expf);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule